// File: doc/BRIEF.md
# Inter-processor interrupt mailbox controller

This block lets each of N processors post short interrupt codes to its peers. Every processor owns a small first-in first-out queue of pending codes and one level-sensitive interrupt line. The line stays high for as long as the queue holds anything. A processor raises an interrupt on a peer by writing a send word. The word names a code in its upper half and a processor index in its lower half. Sends come in two flavours: one that targets the named processor, and one that targets every processor except the named one.

A processor drains its own queue by reading the pending register. Each read hands back the oldest code and removes it from the queue. A read of an empty queue returns zero, so code zero is reserved. A write to the pending register throws away everything that processor still has queued. Writes and reads arrive on two independent channels, and each channel carries its own requester index. A send and a drain can therefore land on the same queue in one cycle. The block resolves that case deterministically: the removal happens first, then the append.

Each queue has a fixed depth. A send aimed at a full queue is dropped, and a sticky overflow flag is set for that processor. The overflow flags of all processors can be read back through a status register.

Top module: `ipi_mbox`

## Requirements
- R1: While reset is held and in the first cycle after it, every irq bit is 0, rd_data is 0, all queues are empty and all overflow flags are clear.
- R2: A write to register 0 (send-one) takes the code from wr_data[31:16] and the target index from wr_data[15:0]. It appends the code only to the queue of the processor whose index equals the target index.
- R3: A write to register 1 (send-all-but) appends the code from wr_data[31:16] to the queue of every processor except the one whose index equals wr_data[15:0]. If that index is N_CPU or more, every processor receives the code.
- R4: Codes leave a queue in the order they entered it, and a queue holds at most DEPTH codes.
- R5: A read strobe at register 2 (pending) with requester rd_id places the head of queue rd_id on rd_data in the following cycle and removes that code from the queue.
- R6: A pending-register read of an empty queue returns 0 on rd_data and leaves the queue empty.
- R7: A write to register 2 by requester wr_id empties queue wr_id and clears its overflow flag, whatever wr_data holds.
- R8: irq[k] is 1 exactly while queue k holds at least one code. It rises in the cycle after the append and falls in the cycle after the access that empties the queue.
- R9: A code sent to a full queue is dropped and sets that processor's sticky overflow flag. A read at register 3 returns the overflow flags in rd_data[N_CPU-1:0], with bit k for processor k, and removes nothing from any queue.
- R10: When a send and a pending-register read hit the same queue in one cycle, the read is served first and then the code is appended. A full queue therefore accepts the code without overflow, and an empty queue returns 0 and ends up holding one code.
- R11: A send-one whose target index is N_CPU or more changes no queue and no overflow flag.
- R12: rd_data keeps its value in every cycle without a read strobe. A read at register 0 or 1 returns 0 and changes no queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe of the write channel |
| wr_id | input | ID_W | Index of the writing processor |
| wr_addr | input | 2 | Register selected by the write |
| wr_data | input | DATA_W | Write data (code in [31:16], target in [15:0]) |
| rd_en | input | 1 | Read strobe of the read channel |
| rd_id | input | ID_W | Index of the reading processor |
| rd_addr | input | 2 | Register selected by the read |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_en |
| irq | output | N_CPU | One interrupt level line per processor |

## Verification
Two operations can hit the same queue in the same cycle, because sends and drains travel on separate channels. One is a send appending a code; the other is a pending-register read removing the head. The bench provokes this on purpose with a full queue and with an empty queue. It then runs a long random phase in which requester and target indices are drawn from a small range, so these collisions recur often. A behavioural reference model built from per-processor queues applies every cycle's read before its write. Its irq vector and rd_data are compared with the design's outputs in every cycle. Any disagreement in the order of operations therefore shows up as a wrong code, a wrong zero or a wrong overflow flag.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

   // Register selector shared by both channels.
   typedef enum logic [1:0] {
      REG_SEND_ONE    = 2'd0,
      REG_SEND_ALLBUT = 2'd1,
      REG_PENDING     = 2'd2,
      REG_OVF_STATUS  = 2'd3
   } ipi_reg_e;

   // Send-word layout: target index in the low field, code above it.
   localparam int TGT_LSB  = 0;
   localparam int TGT_W    = 16;
   localparam int CODE_LSB = TGT_LSB + TGT_W;

endpackage

// File: rtl/ipi_mbox_decode.sv
module ipi_mbox_decode
   import ipi_mbox_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int ID_W   = 2,
   parameter int DATA_W = 32,
   localparam int CODE_W = DATA_W - CODE_LSB
) (
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ID_W-1:0]   rd_id,
   input  logic [1:0]        rd_addr,
   output logic [N_CPU-1:0]  push_mask,
   output logic [N_CPU-1:0]  clr_mask,
   output logic [N_CPU-1:0]  pop_mask,
   output logic [CODE_W-1:0] push_code
);

   logic [TGT_W-1:0] tgt;
   logic             is_one;
   logic             is_allbut;
   logic             is_clr;
   logic             is_pop;

   assign tgt       = wr_data[TGT_LSB +: TGT_W];
   assign push_code = wr_data[CODE_LSB +: CODE_W];
   assign is_one    = wr_en && (wr_addr == REG_SEND_ONE);
   assign is_allbut = wr_en && (wr_addr == REG_SEND_ALLBUT);
   assign is_clr    = wr_en && (wr_addr == REG_PENDING);
   assign is_pop    = rd_en && (rd_addr == REG_PENDING);

   for (genvar k = 0; k < N_CPU; k++) begin : g_lane
      logic hit;
      assign hit          = (tgt == TGT_W'(k));
      assign push_mask[k] = (is_one && hit) || (is_allbut && !hit);
      assign clr_mask[k]  = is_clr && (wr_id == ID_W'(k));
      assign pop_mask[k]  = is_pop && (rd_id == ID_W'(k));
   end

endmodule

// File: rtl/ipi_mbox_queue.sv
module ipi_mbox_queue #(
   parameter int DEPTH  = 8,
   parameter int CODE_W = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [CODE_W-1:0] push_code,
   input  logic              pop,
   input  logic              clr,
   output logic [CODE_W-1:0] head,
   output logic              nonempty,
   output logic              ovf
);

   logic [CODE_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [PTR_W-1:0]  rd_ptr_inc, wr_ptr_inc;
   logic [CNT_W-1:0]  cnt;

   // Pointer wrap: free for power-of-two depths, compare otherwise.
   if (DEPTH == (1 << PTR_W)) begin : g_wrap_pow2
      assign rd_ptr_inc = rd_ptr + 1'b1;
      assign wr_ptr_inc = wr_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   // Order inside one cycle: pop, then clear, then push.
   logic             do_pop;
   logic [CNT_W-1:0] cnt_mid;
   logic [PTR_W-1:0] rd_ptr_mid;
   logic             room;
   logic             do_push;
   logic             drop;

   always_comb begin
      do_pop     = pop && (cnt != '0);
      cnt_mid    = cnt - CNT_W'(do_pop);
      rd_ptr_mid = do_pop ? rd_ptr_inc : rd_ptr;
      if (clr) begin
         cnt_mid    = '0;
         rd_ptr_mid = wr_ptr;
      end
      room    = (cnt_mid != CNT_W'(DEPTH));
      do_push = push && room;
      drop    = push && !room;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else begin
         rd_ptr <= rd_ptr_mid;
         wr_ptr <= do_push ? wr_ptr_inc : wr_ptr;
         cnt    <= cnt_mid + CNT_W'(do_push);
         ovf    <= (ovf && !clr) || drop;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         store[wr_ptr] <= push_code;
      end
   end

   assign head     = store[rd_ptr];
   assign nonempty = (cnt != '0);

endmodule

// File: rtl/ipi_mbox_rd_mux.sv
module ipi_mbox_rd_mux
   import ipi_mbox_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int ID_W   = 2,
   parameter int DATA_W = 32,
   localparam int CODE_W = DATA_W - CODE_LSB
) (
   input  logic [1:0]                   rd_addr,
   input  logic [ID_W-1:0]              rd_id,
   input  logic [N_CPU-1:0][CODE_W-1:0] heads,
   input  logic [N_CPU-1:0]             nonempty,
   input  logic [N_CPU-1:0]             ovf,
   output logic [DATA_W-1:0]            rd_value
);

   logic [CODE_W-1:0] sel_head;
   logic              sel_valid;

   always_comb begin
      sel_head  = '0;
      sel_valid = 1'b0;
      for (int k = 0; k < N_CPU; k++) begin
         if (rd_id == ID_W'(k)) begin
            sel_head  = heads[k];
            sel_valid = nonempty[k];
         end
      end
   end

   always_comb begin
      rd_value = '0;
      unique case (rd_addr)
         REG_PENDING:    rd_value = sel_valid ? DATA_W'(sel_head) : '0;
         REG_OVF_STATUS: rd_value = DATA_W'(ovf);
         default:        rd_value = '0;
      endcase
   end

endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
   import ipi_mbox_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   localparam int ID_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1,
   localparam int CODE_W = DATA_W - CODE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ID_W-1:0]   rd_id,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [N_CPU-1:0]  irq
);

   initial begin
      assert (N_CPU >= 2 && N_CPU <= DATA_W)
         else $error("ipi_mbox: N_CPU must lie in 2..DATA_W");
      assert (DEPTH >= 2)
         else $error("ipi_mbox: DEPTH must be at least 2");
      assert (DATA_W > CODE_LSB)
         else $error("ipi_mbox: DATA_W must leave room for a code field");
   end

   logic [N_CPU-1:0]             push_mask, clr_mask, pop_mask;
   logic [CODE_W-1:0]            push_code;
   logic [N_CPU-1:0][CODE_W-1:0] heads;
   logic [N_CPU-1:0]             nonempty;
   logic [N_CPU-1:0]             ovf_flags;
   logic [DATA_W-1:0]            rd_value;

   ipi_mbox_decode #(
      .N_CPU (N_CPU),
      .ID_W  (ID_W),
      .DATA_W(DATA_W)
   ) u_decode (
      .wr_en    (wr_en),
      .wr_id    (wr_id),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_id    (rd_id),
      .rd_addr  (rd_addr),
      .push_mask(push_mask),
      .clr_mask (clr_mask),
      .pop_mask (pop_mask),
      .push_code(push_code)
   );

   for (genvar k = 0; k < N_CPU; k++) begin : g_q
      ipi_mbox_queue #(
         .DEPTH (DEPTH),
         .CODE_W(CODE_W)
      ) u_queue (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_mask[k]),
         .push_code(push_code),
         .pop      (pop_mask[k]),
         .clr      (clr_mask[k]),
         .head     (heads[k]),
         .nonempty (nonempty[k]),
         .ovf      (ovf_flags[k])
      );
   end

   ipi_mbox_rd_mux #(
      .N_CPU (N_CPU),
      .ID_W  (ID_W),
      .DATA_W(DATA_W)
   ) u_rd_mux (
      .rd_addr (rd_addr),
      .rd_id   (rd_id),
      .heads   (heads),
      .nonempty(nonempty),
      .ovf     (ovf_flags),
      .rd_value(rd_value)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_value;
      end
   end

   assign irq = nonempty;

endmodule

// File: rtl/ipi_mbox_chk.sv
module ipi_mbox_chk
   import ipi_mbox_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int DATA_W = 32,
   parameter int ID_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ID_W-1:0]   wr_id,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ID_W-1:0]   rd_id,
   input logic [1:0]        rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [N_CPU-1:0]  irq,
   input logic [N_CPU-1:0]  ovf_flags
);

   // R12: read data only moves on a read strobe.
   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   for (genvar k = 0; k < N_CPU; k++) begin : g_k
      // R2 / R8: a send-one to k leaves k interrupted.
      assert_send_one_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == REG_SEND_ONE && wr_data[TGT_W-1:0] == TGT_W'(k))
         |=> irq[k]);

      // R3: the excluded processor gains nothing from a send-all-but.
      assert_allbut_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == REG_SEND_ALLBUT && wr_data[TGT_W-1:0] == TGT_W'(k) && !irq[k])
         |=> !irq[k]);

      // R7: a discard leaves the queue empty and the flag clear.
      assert_discard_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == REG_PENDING && wr_id == ID_W'(k))
         |=> (!irq[k] && !ovf_flags[k]));

      // R6: reading an empty queue yields zero.
      assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && rd_addr == REG_PENDING && rd_id == ID_W'(k) && !irq[k])
         |=> (rd_data == '0));

      // R9: the overflow flag is sticky until a discard by its owner.
      assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_flags[k] && !(wr_en && wr_addr == REG_PENDING && wr_id == ID_W'(k)))
         |=> ovf_flags[k]);

      // R9 / R8: an overflowing queue is never empty.
      assert_ovf_implies_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_flags[k]) |-> irq[k]);
   end

endmodule

bind ipi_mbox ipi_mbox_chk #(
   .N_CPU (N_CPU),
   .DATA_W(DATA_W),
   .ID_W  (ID_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_id    (wr_id),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .rd_en    (rd_en),
   .rd_id    (rd_id),
   .rd_addr  (rd_addr),
   .rd_data  (rd_data),
   .irq      (irq),
   .ovf_flags(ovf_flags)
);

// File: tb/ipi_mbox_tb.sv
`timescale 1ns/1ps
module ipi_mbox_tb;

   localparam int N      = 4;
   localparam int D      = 8;
   localparam int DW     = 32;
   localparam int IDW    = 2;
   localparam real TCLK  = 20.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IDW-1:0] wr_id = '0;
   logic [1:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [IDW-1:0] rd_id = '0;
   logic [1:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [N-1:0]  irq;

   always #(TCLK / 2.0) clk = ~clk;

   ipi_mbox #(.N_CPU(N), .DEPTH(D), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_id(wr_id), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_id(rd_id), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R1";

   // Reference model.
   int unsigned   mq [N][$];
   bit [N-1:0]    movf;
   logic [DW-1:0] mrd;

   function automatic void m_push(int k, int unsigned code);
      if (mq[k].size() < D) mq[k].push_back(code);
      else movf[k] = 1'b1;
   endfunction

   function automatic void m_apply(bit we, int wid, int wa, logic [DW-1:0] wd,
                                   bit re, int rid, int ra);
      int unsigned code = wd[31:16];
      int unsigned tgt  = wd[15:0];
      if (re) begin
         if (ra == 2) mrd = (mq[rid].size() > 0) ? DW'(mq[rid].pop_front()) : '0;
         else if (ra == 3) mrd = DW'(movf);
         else mrd = '0;
      end
      if (we) begin
         if (wa == 0) begin
            if (tgt < N) m_push(int'(tgt), code);
         end else if (wa == 1) begin
            for (int k = 0; k < N; k++) if (k != int'(tgt)) m_push(k, code);
         end else if (wa == 2) begin
            mq[wid].delete();
            movf[wid] = 1'b0;
         end
      end
   endfunction

   function automatic logic [N-1:0] m_irq();
      logic [N-1:0] v;
      for (int k = 0; k < N; k++) v[k] = (mq[k].size() > 0);
      return v;
   endfunction

   task automatic compare();
      n_vec++;
      if (irq !== m_irq()) begin
         n_bad++;
         $display("FAIL %s (R8 irq) at %0t: got %b exp %b", phase, $time, irq, m_irq());
      end
      if (rd_data !== mrd) begin
         n_bad++;
         $display("FAIL %s (R5 rd_data) at %0t: got %h exp %h", phase, $time, rd_data, mrd);
      end
   endtask

   // Drive one cycle, then update the model and compare at the next falling edge.
   task automatic step(bit we, int wid, int wa, logic [DW-1:0] wd,
                       bit re, int rid, int ra);
      wr_en = we; wr_id = IDW'(wid); wr_addr = 2'(wa); wr_data = wd;
      rd_en = re; rd_id = IDW'(rid); rd_addr = 2'(ra);
      @(negedge clk);
      m_apply(we, wid, wa, wd, re, rid, ra);
      compare();
   endtask

   task automatic send_one(int tgt, int code);
      step(1, 0, 0, {16'(code), 16'(tgt)}, 0, 0, 0);
   endtask
   task automatic send_allbut(int tgt, int code);
      step(1, 0, 1, {16'(code), 16'(tgt)}, 0, 0, 0);
   endtask
   task automatic drain(int who);
      step(0, 0, 0, '0, 1, who, 2);
   endtask
   task automatic idle();
      step(0, 0, 0, '0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
   end

   initial begin
      movf = '0;
      mrd  = '0;
      repeat (3) @(negedge clk);
      // R1: reset state while reset is held.
      phase = "R1 reset";
      compare();
      rst_n = 1'b1;
      idle();

      // R2 R4 R5 R8: ordered delivery to one processor.
      phase = "R2/R4/R5";
      send_one(1, 16'h0011);
      send_one(1, 16'h0022);
      send_one(1, 16'h0033);
      drain(1); drain(1);
      phase = "R8 drop after last";
      drain(1);
      // R6: empty read gives zero.
      phase = "R6 empty";
      drain(1);

      // R3: broadcast to all but processor 2, then drain everyone.
      phase = "R3 allbut";
      send_allbut(2, 16'h0A5A);
      for (int k = 0; k < N; k++) drain(k);
      send_allbut(7, 16'h0B0B);
      for (int k = 0; k < N; k++) drain(k);

      // R11: out-of-range send-one is ignored.
      phase = "R11 bad index";
      send_one(4, 16'h0C0C);
      send_one(16'hFFFF, 16'h0C0D);
      step(0, 0, 0, '0, 1, 0, 3);

      // R9: overflow on processor 0, status readback does not pop.
      phase = "R9 overflow";
      for (int i = 0; i < D + 1; i++) send_one(0, 16'h0100 + i);
      step(0, 0, 0, '0, 1, 0, 3);
      step(0, 0, 0, '0, 1, 0, 3);
      drain(0); drain(0);

      // R7: discard clears queue and overflow flag.
      phase = "R7 discard";
      step(1, 0, 2, 32'hDEAD_BEEF, 0, 0, 0);
      step(0, 0, 0, '0, 1, 0, 3);
      drain(0);

      // R10: same-cycle pop and push, full queue then empty queue.
      phase = "R10 collide full";
      for (int i = 0; i < D; i++) send_one(3, 16'h0300 + i);
      step(1, 0, 0, {16'h03FF, 16'd3}, 1, 3, 2);
      step(0, 0, 0, '0, 1, 0, 3);
      phase = "R10 collide empty";
      step(1, 0, 0, {16'h0222, 16'd2}, 1, 2, 2);
      drain(2);
      phase = "R10 collide discard";
      step(1, 3, 2, '0, 1, 3, 2);

      // R12: idle holds rd_data; reads of send registers give zero.
      phase = "R12 hold";
      send_one(0, 16'h0777);
      drain(0);
      idle(); idle();
      step(0, 0, 0, '0, 1, 1, 0);
      step(0, 0, 0, '0, 1, 1, 1);

      // Random phase with frequent collisions.
      phase = "R4/R10 random";
      for (int i = 0; i < 4000; i++) begin
         int wa  = $urandom_range(0, 9);
         int tgt = ($urandom_range(0, 7) == 0) ? $urandom_range(4, 9) : $urandom_range(0, N - 1);
         bit we  = ($urandom_range(0, 3) != 0);
         bit re  = ($urandom_range(0, 2) != 0);
         int ra  = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 3) : 2;
         wa = (wa < 5) ? 0 : (wa < 8) ? 1 : (wa < 9) ? 2 : 3;
         step(we, $urandom_range(0, N - 1), wa,
              {16'($urandom_range(1, 65535)), 16'(tgt)},
              re, $urandom_range(0, N - 1), ra);
      end

      summary();
      $finish;
   end

endmodule